// File: doc/BRIEF.md
# Three-Wire Serial Register Port

A slave control port that gives a host access to a bank of 16-bit registers over three lines: a serial clock, a mode line and a data line. The data line is split at the block edge into an input, an output and an output enable, so it can be joined to a shared pad. The serial lines are brought into the system clock domain by synchronisers. Bits are taken on each detected rising edge of the serial clock, and every byte moves least significant bit first.

With the mode line low the host sends a device-address byte. That byte selects the block and names the transfer type. With the mode line high the host sends or receives the bytes of that transfer. A write carries a command/register byte and two data bytes, and ends in a one-cycle write strobe to the register bank. A read takes two steps. First a prepare-read records the register address. Then a read-type address phase makes the port drive a status/address byte and the two data bytes back onto the line.

Top module: `ser_reg_port`

## Requirements
- R1: After `rst_ni` is released, register i holds DEF_SEED + i*DEF_STEP (16 bits, with 12 registers by default), and `sdata_oe_o` is low.
- R2: The first rising serial-clock edge after reset only wakes the port; the bit it carries is discarded, so a transfer sent without a prior wake pulse loses its first bit and has no effect.
- R3: While the mode line is low, the port takes 8 bits LSB first. Bits 7..2 are compared with DEV_ADDR, and bits 1..0 give the type: 2'b10 is write/prepare-read and 2'b11 is read. Types 2'b00 and 2'b01 are ignored.
- R4: In a write-type data phase, the first byte carries the command in bit 0 (0 = write) and the register address in bits 7..1. The MS data byte follows, then the LS data byte. After the 24th bit, `wr_en_o` pulses for one cycle, carrying the address and data, and the register takes the value.
- R5: Once a write completes, further bytes in the same data phase are ignored; another write needs a new device-address phase.
- R6: When command bit 0 is 1 (prepare-read), bits 7..1 are recorded as the read address and no write takes place.
- R7: In the data phase after a read-type address phase, the port drives 24 bits, each LSB first. Byte 0 has bit 0 = 0 for a valid address or 1 for an invalid one, and bits 7..1 = the recorded address. Byte 1 is the MS data byte and byte 2 is the LS data byte.
- R8: Addresses at or above NUM_REGS are invalid: they read as flag 1 with data 0, and writes to them raise no strobe.
- R9: `sdata_oe_o` is high only during the 24 returned bits of a read. It is low in address phases, in write phases and after the 24th bit.
- R10: A device-address byte whose bits 7..2 differ from DEV_ADDR causes the following data phase to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; restores register defaults |
| sclk_i | input | 1 | Serial clock, idles high |
| mode_i | input | 1 | Mode line: low = device-address phase, high = data phase |
| sdata_i | input | 1 | Serial data from host |
| sdata_o | output | 1 | Serial data to host during reads |
| sdata_oe_o | output | 1 | Output enable for the shared data line |
| wr_en_o | output | 1 | One-cycle write strobe to the register bank |
| wr_addr_o | output | 7 | Register address of the strobed write |
| wr_data_o | output | 16 | Data of the strobed write |

## Verification
The bench aims at the edges of the byte framing. It tests the wake edge after reset: a design that does not discard that edge would accept the misaligned write, and the later readback would show the wrong value. It tests extra bytes after a complete write, bad type codes and a foreign device address: a design that gets these wrong raises stray write strobes, and the scoreboard reports them as unexpected. It reads both out-of-range and in-range addresses, which catches a wrong validity flag, swapped data bytes or a wrong bit order in the returned word. It also checks that the output enable falls after the 24th bit and stays low during write data and in aborted transfers.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int TXW = 8 + DW;
  localparam logic [1:0] TYPE_WR = 2'b10;
  localparam logic [1:0] TYPE_RD = 2'b11;
  typedef enum logic [1:0] {SEL_NONE, SEL_WR, SEL_RD} sel_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= {STAGES{RST_VAL[i]}};
      else         pipe <= {pipe[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import ser_reg_pkg::*;
#(
  parameter int          NUM_REGS = 12,
  parameter logic [DW-1:0] DEF_SEED = 16'h1200,
  parameter logic [DW-1:0] DEF_STEP = 16'h0111
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic [DW-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[i] <= DW'(DEF_SEED + DW'(i) * DEF_STEP);
      else if (wr_en_i && wr_addr_i == AW'(i)) regs[i] <= wr_data_i;
    end
  end

  assign rd_valid_o = {1'b0, rd_addr_i} < (AW + 1)'(NUM_REGS);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = regs[i];
  end

  assert_wr_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ({1'b0, wr_addr_i} < (AW + 1)'(NUM_REGS)));
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import ser_reg_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'h1E,
  parameter int         NUM_REGS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_s_i,
  input  logic          mode_s_i,
  input  logic          data_s_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_valid_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdata_o,
  output logic          oe_o
);
  sel_e       sel;
  logic       sclk_q, mode_q, awake;
  logic [4:0] bit_cnt;
  logic [7:0] shreg, msb_q, nb;
  logic       rise, mode_chg;
  logic [TXW-1:0] tx;

  assign rise     = sclk_s_i & ~sclk_q;
  assign mode_chg = mode_s_i ^ mode_q;
  assign nb       = {data_s_i, shreg[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1; mode_q <= 1'b1; awake <= 1'b0; sel <= SEL_NONE;
      bit_cnt <= '0; shreg <= '0; msb_q <= '0; rd_addr_o <= '0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      sclk_q  <= sclk_s_i;
      mode_q  <= mode_s_i;
      wr_en_o <= 1'b0;
      if (mode_chg) begin
        bit_cnt <= '0;
        if (!mode_s_i) sel <= SEL_NONE;
      end else if (rise) begin
        if (!awake) awake <= 1'b1;           // wake edge carries no bit
        else if (!mode_s_i) begin
          if (bit_cnt < 5'd8) begin
            shreg   <= nb;
            bit_cnt <= bit_cnt + 5'd1;
            if (bit_cnt == 5'd7) begin
              if (nb[7:2] != DEV_ADDR)   sel <= SEL_NONE;
              else if (nb[1:0] == TYPE_WR) sel <= SEL_WR;
              else if (nb[1:0] == TYPE_RD) sel <= SEL_RD;
              else                         sel <= SEL_NONE;
            end
          end
        end else if (sel == SEL_WR) begin
          shreg   <= nb;
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt == 5'd7) begin
            if (nb[0]) begin rd_addr_o <= nb[7:1]; sel <= SEL_NONE; end
            else wr_addr_o <= nb[7:1];
          end
          if (bit_cnt == 5'd15) msb_q <= nb;
          if (bit_cnt == 5'd23) begin
            wr_en_o   <= {1'b0, wr_addr_o} < (AW + 1)'(NUM_REGS);
            wr_data_o <= {msb_q, nb};
            sel       <= SEL_NONE;
          end
        end else if (sel == SEL_RD) begin
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt == 5'd23) sel <= SEL_NONE;
        end
      end
    end
  end

  assign tx      = {rd_data_i[7:0], rd_data_i[15:8], rd_addr_o, ~rd_valid_i};
  assign oe_o    = (sel == SEL_RD) & mode_s_i & mode_q;
  assign sdata_o = (oe_o && bit_cnt < 5'd24) ? tx[bit_cnt] : 1'b0;

  assert_wr_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  assert_asleep_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake |-> (sel == SEL_NONE && !wr_en_o));
  assert_no_oe_in_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s_i |-> !oe_o);
  assert_oe_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && rise && !mode_chg && bit_cnt == 5'd23) |=> !oe_o);
  assert_bitcnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 5'd24);
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter logic [5:0]    DEV_ADDR    = 6'h1E,
  parameter int            NUM_REGS    = 12,
  parameter logic [15:0]   DEF_SEED    = 16'h1200,
  parameter logic [15:0]   DEF_STEP    = 16'h0111,
  parameter int            SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        mode_i,
  input  logic        sdata_i,
  output logic        sdata_o,
  output logic        sdata_oe_o,
  output logic        wr_en_o,
  output logic [6:0]  wr_addr_o,
  output logic [15:0] wr_data_o
);
  logic [2:0]    sync_q;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sdata_i, mode_i, sclk_i}), .q_o(sync_q)
  );

  srp_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_s_i(sync_q[0]), .mode_s_i(sync_q[1]), .data_s_i(sync_q[2]),
    .rd_data_i(rd_data), .rd_valid_i(rd_valid), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .sdata_o(sdata_o), .oe_o(sdata_oe_o)
  );

  srp_bank #(.NUM_REGS(NUM_REGS), .DEF_SEED(DEF_SEED), .DEF_STEP(DEF_STEP)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_o), .wr_addr_i(wr_addr_o), .wr_data_i(wr_data_o),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );
endmodule

// File: tb/tb_ser_reg_port.sv
module tb_ser_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [5:0] DEV = 6'h1E;
  localparam int NREG = 12;
  localparam logic [15:0] SEED = 16'h1200;
  localparam logic [15:0] STEP = 16'h0111;

  logic clk = 0, rst_n = 0, sclk = 1, mode = 1, sdi = 0;
  logic sdo, oe, wr_en;
  logic [6:0] wr_addr;
  logic [15:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_reg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mode_i(mode), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe_o(oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [NREG];
  logic [22:0] exp_wr_q [$];
  logic [23:0] exp_rd_q [$];
  string       rd_tag_q [$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic reset_model();
    for (int i = 0; i < NREG; i++) model[i] = 16'(SEED + 16'(i) * STEP);
  endtask

  task automatic send_bit(logic b);
    sdi = b; sclk = 0;
    repeat (HALF) @(posedge clk);
    sclk = 1;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic set_mode(logic m);
    mode = m;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic addr_phase(logic [5:0] dev, logic [1:0] typ);
    set_mode(0);
    send_byte({dev, typ});
    set_mode(1);
  endtask

  task automatic write_raw(logic [5:0] dev, logic [1:0] typ, logic [6:0] a, logic [15:0] d, int extra);
    addr_phase(dev, typ);
    send_byte({a, 1'b0});
    send_byte(d[15:8]);
    send_byte(d[7:0]);
    for (int i = 0; i < extra; i++) send_byte(8'h77);
    repeat (6) @(posedge clk);
  endtask

  task automatic write_reg(logic [6:0] a, logic [15:0] d);
    exp_wr_q.push_back({a, d});
    model[a] = d;
    write_raw(DEV, 2'b10, a, d, 0);
    check(exp_wr_q.size() == 0, "R4", exp_wr_q.size(), 0, "write strobe missing");
  endtask

  task automatic prep(logic [6:0] a);
    addr_phase(DEV, 2'b10);
    send_byte({a, 1'b1});
  endtask

  task automatic fetch(logic [6:0] a, string tag);
    bit valid;
    logic [15:0] v;
    valid = int'(a) < NREG;
    v = valid ? model[int'(a)] : 16'h0;
    addr_phase(DEV, 2'b11);
    exp_rd_q.push_back({v[7:0], v[15:8], a, ~valid});
    rd_tag_q.push_back(tag);
    for (int i = 0; i < 24; i++) send_bit(0);
    repeat (6) @(negedge clk);
    check(oe == 0, "R9", oe, 0, "oe after 24 bits");
    check(exp_rd_q.size() == 0, tag, exp_rd_q.size(), 0, "readback missing");
    exp_rd_q.delete(); rd_tag_q.delete();
  endtask

  task automatic read_reg(logic [6:0] a, string tag);
    prep(a);
    fetch(a, tag);
  endtask

  // monitor: readback words
  int mon_bit = 0;
  logic [23:0] got, expw;
  string tag_cur;
  always @(posedge sclk) begin
    if (oe) begin
      got[mon_bit] = sdo;
      mon_bit++;
      if (mon_bit == 24) begin
        mon_bit = 0;
        if (exp_rd_q.size() == 0) check(0, "R9", 32'(got), 0, "unexpected readback");
        else begin
          expw = exp_rd_q.pop_front();
          tag_cur = rd_tag_q.pop_front();
          check(got == expw, tag_cur, 32'(got), 32'(expw), "readback word");
        end
      end
    end
  end

  // monitor: write strobes
  logic [22:0] expwr;
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_wr_q.size() == 0) check(0, "R5", 32'({wr_addr, wr_data}), 0, "unexpected write strobe");
      else begin
        expwr = exp_wr_q.pop_front();
        check({wr_addr, wr_data} == expwr, "R4", 32'({wr_addr, wr_data}), 32'(expwr), "write strobe");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    reset_model();
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(oe == 0 && wr_en == 0, "R1", {oe, wr_en}, 0, "outputs in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(oe == 0, "R1", oe, 0, "oe after reset");

    // R2: no wake pulse, first bit eaten, write has no effect
    write_raw(DEV, 2'b10, 7'd1, 16'hBEEF, 0);
    read_reg(7'd1, "R2");

    for (int i = 0; i < NREG; i++) read_reg(7'(i), "R1");

    write_reg(7'd3, 16'hA55A);
    read_reg(7'd3, "R4");
    write_reg(7'd0, 16'h0001);
    read_reg(7'd0, "R4");

    // R5: trailing bytes ignored
    exp_wr_q.push_back({7'd7, 16'h3C81});
    model[7] = 16'h3C81;
    write_raw(DEV, 2'b10, 7'd7, 16'h3C81, 2);
    check(exp_wr_q.size() == 0, "R5", exp_wr_q.size(), 0, "write before trailing bytes");
    read_reg(7'd7, "R5");

    // R3: unused type codes
    write_raw(DEV, 2'b00, 7'd4, 16'h1234, 0);
    write_raw(DEV, 2'b01, 7'd4, 16'h5678, 0);
    read_reg(7'd4, "R3");

    // R10: foreign device address
    write_raw(DEV ^ 6'h01, 2'b10, 7'd5, 16'hDEAD, 0);
    addr_phase(DEV ^ 6'h01, 2'b11);
    for (int i = 0; i < 8; i++) begin
      send_bit(0);
      check(oe == 0, "R10", oe, 0, "oe for foreign read");
    end
    read_reg(7'd5, "R10");

    // R8: invalid addresses
    write_raw(DEV, 2'b10, 7'h50, 16'hFFFF, 0);
    read_reg(7'h50, "R8");
    read_reg(7'h7F, "R8");
    read_reg(7'(NREG), "R8");

    // R6: prepare-read records address, no write; read repeats without new prepare
    prep(7'd6);
    repeat (6) @(posedge clk);
    fetch(7'd6, "R6");
    fetch(7'd6, "R6");

    // R9: oe stays low in write data, aborted write gives no strobe
    addr_phase(DEV, 2'b10);
    send_byte({7'd2, 1'b0});
    @(negedge clk);
    check(oe == 0, "R9", oe, 0, "oe during write data");
    send_byte(8'hAB);
    set_mode(0);
    set_mode(1);
    read_reg(7'd2, "R9");

    // R1: reset restores defaults
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    reset_model();
    send_bit(0);  // wake pulse
    read_reg(7'd3, "R1");
    read_reg(7'd7, "R1");

    check(exp_wr_q.size() == 0, "R4", exp_wr_q.size(), 0, "pending writes at end");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule